// File: doc/BRIEF.md
# Double-Word Funnel Shifter

A combinational shifter for one machine word, moving a source word left or right by 0 to WIDTH-1 bit positions. The positions the shift empties are not zero-filled. They are loaded with the matching positions of a second input, the fill word. On a left shift these are the fill word's low bits. On a right shift they are its high bits.

The bits pushed out of the source are not lost. They come out on a separate spill word, aligned so that the spill of one step can serve directly as the fill word of the next step. A word-serial shift of an arbitrarily long integer therefore needs one pass of this block per word. An overflow flag reports that the spill word is nonzero, and it is gated by a flag-enable input.

The block has no clock and no state. Every output follows its inputs in the same cycle. It carries no data stream, so all pins are plain levels with no valid/ready handshake and no back-pressure.

Top module: `funnel_shift64`

## Requirements
- R1: The shift count n is the low 6 bits (log2 of WIDTH) of `amt_i`; every higher bit of `amt_i` has no effect on any output.
- R2: With `dir_right_i` = 0 (left), `result_o` equals `src_i` shifted left by n, with bits [n-1:0] taken from bits [n-1:0] of `fill_i`.
- R3: With `dir_right_i` = 0, `spill_o` bits [n-1:0] hold bits [63:64-n] of `src_i`, and all higher bits of `spill_o` are zero.
- R4: With `dir_right_i` = 1 (right), `result_o` equals `src_i` shifted right by n, with bits [63:64-n] taken from bits [63:64-n] of `fill_i`.
- R5: With `dir_right_i` = 1, `spill_o` bits [63:64-n] hold bits [n-1:0] of `src_i`, and all lower bits of `spill_o` are zero.
- R6: With `flag_en_i` = 1, `ovf_o` is 1 exactly when `spill_o` is nonzero.
- R7: With `flag_en_i` = 0, `ovf_o` is 0 whatever the spill word holds.
- R8: With n = 0, `result_o` equals `src_i` and `spill_o` is zero in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Word to be shifted |
| fill_i | input | 64 | Word supplying the bits that enter the vacated positions |
| amt_i | input | 64 | Shift operand; only the low 6 bits are used |
| dir_right_i | input | 1 | 0 = shift left, 1 = shift right |
| flag_en_i | input | 1 | Enables the overflow flag |
| result_o | output | 64 | Shifted word merged with fill bits |
| spill_o | output | 64 | Bits shifted out of the source, aligned for chaining |
| ovf_o | output | 1 | Spill word nonzero, when enabled |

## Verification
Two situations are the hardest to reach from the ports. One is a shift operand whose upper bits are set while its low 6 bits are zero or small. The other is the end of the range, n = 63, where the spill word holds all but one bit of the source. The stimulus reaches both in two ways. Vector entries carry operands with stray high bits and n at 0 and 63. A sweep of every n in both directions, with the flag both enabled and disabled, is then compared against a 128-bit concatenate-and-shift reference.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned FS_WIDTH = 64;

  typedef enum logic {
    FS_LEFT  = 1'b0,
    FS_RIGHT = 1'b1
  } fs_dir_e;
endpackage

// File: rtl/fs_rotator.sv
module fs_rotator #(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic [SHW-1:0]   n_i,
  input  fs_pkg::fs_dir_e  dir_i,
  output logic [WIDTH-1:0] rot_o
);
  logic [2*WIDTH-1:0] doubled;
  logic [2*WIDTH-1:0] lshift;
  logic [2*WIDTH-1:0] rshift;

  always_comb begin
    doubled = {word_i, word_i};
    lshift  = doubled << n_i;
    rshift  = doubled >> n_i;
    if (dir_i == fs_pkg::FS_RIGHT) rot_o = rshift[WIDTH-1:0];
    else                           rot_o = lshift[2*WIDTH-1:WIDTH];
  end
endmodule

// File: rtl/fs_mask_gen.sv
module fs_mask_gen #(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [SHW-1:0]   n_i,
  input  fs_pkg::fs_dir_e  dir_i,
  output logic [WIDTH-1:0] keep_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  always_comb begin
    if (dir_i == fs_pkg::FS_RIGHT) keep_o = ALL_ONES >> n_i;
    else                           keep_o = ALL_ONES << n_i;
  end
endmodule

// File: rtl/fs_merge.sv
module fs_merge #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] rot_i,
  input  logic [WIDTH-1:0] keep_i,
  input  logic [WIDTH-1:0] fill_i,
  input  logic             flag_en_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] spill_o,
  output logic             ovf_o
);
  always_comb begin
    result_o = (rot_i & keep_i) | (fill_i & ~keep_i);
    spill_o  = rot_i & ~keep_i;
    ovf_o    = flag_en_i & (|spill_o);
  end
endmodule

// File: rtl/funnel_shift64.sv
module funnel_shift64 #(
  parameter int unsigned WIDTH = fs_pkg::FS_WIDTH,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src_i,
  input  logic [WIDTH-1:0] fill_i,
  input  logic [WIDTH-1:0] amt_i,
  input  logic             dir_right_i,
  input  logic             flag_en_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] spill_o,
  output logic             ovf_o
);
  logic [SHW-1:0]   n;
  fs_pkg::fs_dir_e  dir;
  logic [WIDTH-1:0] rot;
  logic [WIDTH-1:0] keep;

  assign n   = amt_i[SHW-1:0];
  assign dir = dir_right_i ? fs_pkg::FS_RIGHT : fs_pkg::FS_LEFT;

  fs_rotator #(.WIDTH(WIDTH)) u_rot (
    .word_i (src_i),
    .n_i    (n),
    .dir_i  (dir),
    .rot_o  (rot)
  );

  fs_mask_gen #(.WIDTH(WIDTH)) u_mask (
    .n_i    (n),
    .dir_i  (dir),
    .keep_o (keep)
  );

  fs_merge #(.WIDTH(WIDTH)) u_merge (
    .rot_i     (rot),
    .keep_i    (keep),
    .fill_i    (fill_i),
    .flag_en_i (flag_en_i),
    .result_o  (result_o),
    .spill_o   (spill_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/funnel_shift64_chk.sv
module funnel_shift64_chk #(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] src_i,
  input logic [WIDTH-1:0] fill_i,
  input logic [WIDTH-1:0] amt_i,
  input logic             dir_right_i,
  input logic             flag_en_i,
  input logic [WIDTH-1:0] result_o,
  input logic [WIDTH-1:0] spill_o,
  input logic             ovf_o
);
  logic [SHW-1:0] n;
  logic           known;
  assign n     = amt_i[SHW-1:0];
  assign known = !$isunknown({src_i, fill_i, amt_i, dir_right_i, flag_en_i,
                              result_o, spill_o, ovf_o});

  always_comb begin
    if (known) begin
      // R3
      left_spill_high_zero_chk: assert (dir_right_i || ((spill_o >> n) == '0));
      // R5
      right_spill_low_zero_chk: assert (!dir_right_i || ((spill_o << n) == '0));
      // R2
      left_fill_bits_chk: assert (dir_right_i ||
        (((result_o ^ fill_i) & ~({WIDTH{1'b1}} << n)) == '0));
      // R4
      right_fill_bits_chk: assert (!dir_right_i ||
        (((result_o ^ fill_i) & ~({WIDTH{1'b1}} >> n)) == '0));
      // R6
      overflow_has_spill_chk: assert (!ovf_o || (spill_o != '0));
      // R7
      no_overflow_chk: assert (flag_en_i || !ovf_o);
      // R8
      zero_shift_pass_chk: assert ((n != '0) || ((result_o == src_i) && (spill_o == '0)));
    end
  end
endmodule

bind funnel_shift64 funnel_shift64_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/funnel_shift64_test.sv
module funnel_shift64_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] src, fill, amt;
  logic        dir_r, fen;
  logic [63:0] res, spl;
  logic        ovf;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  funnel_shift64 uut (
    .src_i(src), .fill_i(fill), .amt_i(amt), .dir_right_i(dir_r),
    .flag_en_i(fen), .result_o(res), .spill_o(spl), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [63:0] s, f, a;
    logic        d, e;
    logic [63:0] xr, xs;
    logic        xo;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R2 R3 R6: one-bit left shift, top bit spills
    '{64'h8000_0000_0000_0001, 64'h0, 64'd1, 1'b0, 1'b1, 64'h2, 64'h1, 1'b1},
    // R4 R5 R6: one-bit right shift, bottom bit spills into the top
    '{64'h8000_0000_0000_0001, 64'h0, 64'd1, 1'b1, 1'b1, 64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1},
    // R2 R7: nibble left, fill ones enter the bottom, flag disabled
    '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEFF, 64'h0, 1'b0},
    // R4 R5: nibble right, fill ones enter the top
    '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd4, 1'b1, 1'b1, 64'hF012_3456_789A_BCDE, 64'hF000_0000_0000_0000, 1'b1},
    // R1 R8: high operand bits set, n = 0
    '{64'h0000_0000_DEAD_BEEF, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_FFC0, 1'b0, 1'b1, 64'h0000_0000_DEAD_BEEF, 64'h0, 1'b0},
    // R1 R3: operand 0x108 gives n = 8
    '{64'hAA00_0000_0000_0000, 64'h1234, 64'h108, 1'b0, 1'b1, 64'h34, 64'hAA, 1'b1},
    // R5: n = 63 right
    '{64'h1, 64'h0, 64'd63, 1'b1, 1'b1, 64'h0, 64'h2, 1'b1},
    // R2 R6: n = 63 left, spill zero so no flag
    '{64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0}
  };

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] s, f, a, input logic d, e);
    @(negedge clk);
    src = s; fill = f; amt = a; dir_r = d; fen = e;
    #2;
  endtask

  task automatic ref_check(input logic [63:0] s, f, a, input logic d, e);
    logic [127:0] w;
    logic [63:0]  xr, xs;
    int unsigned  k;
    k = a[5:0];
    if (!d) begin
      w  = {64'h0, s} << k;
      xs = w[127:64];
      xr = w[63:0] | (f & ~({64{1'b1}} << k));
    end else begin
      w  = {s, 64'h0} >> k;
      xs = w[63:0];
      xr = w[127:64] | (f & ~({64{1'b1}} >> k));
    end
    apply(s, f, a, d, e);
    check64(d ? "R4 result" : "R2 result", res, xr);
    check64(d ? "R5 spill" : "R3 spill", spl, xs);
    check64(e ? "R6 ovf" : "R7 ovf", {63'h0, ovf}, {63'h0, e & (xs != 0)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    src = '0; fill = '0; amt = '0; dir_r = 1'b0; fen = 1'b0;
    // reset state: all-zero inputs give all-zero outputs (R8)
    apply('0, '0, '0, 1'b0, 1'b0);
    check64("R8 idle result", res, 64'h0);
    check64("R8 idle spill", spl, 64'h0);
    check64("R7 idle ovf", {63'h0, ovf}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].s, VECS[i].f, VECS[i].a, VECS[i].d, VECS[i].e);
      check64($sformatf("vec%0d R2/R4 result", i), res, VECS[i].xr);
      check64($sformatf("vec%0d R3/R5 spill", i), spl, VECS[i].xs);
      check64($sformatf("vec%0d R6/R7 ovf", i), {63'h0, ovf}, {63'h0, VECS[i].xo});
    end

    // full sweep of n in both directions, flag enabled and disabled
    for (int d = 0; d < 2; d++) begin
      for (int n = 0; n < 64; n++) begin
        ref_check(64'hC3A5_0F96_1E2D_B487, 64'h9E37_79B9_7F4A_7C15,
                  {58'h2AB_CDEF_0123_45 , 6'(n)}, d[0], 1'b1);
        ref_check(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'(n), d[0], 1'b0);
      end
    end

    // R1: upper operand bits alone do not change outputs
    apply(64'h0123_4567_89AB_CDEF, 64'h0, 64'hFFFF_FFFF_FFFF_FFC0, 1'b1, 1'b1);
    check64("R1 result with n=0", res, 64'h0123_4567_89AB_CDEF);
    check64("R1 spill with n=0", spl, 64'h0);

    // R7: large spill but flag disabled
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd32, 1'b0, 1'b0);
    check64("R7 spill present", spl, 64'h0000_0000_FFFF_FFFF);
    check64("R7 ovf gated", {63'h0, ovf}, 64'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule